// File: doc/BRIEF.md
# Shift-and-Clamp Unsigned Saturation Unit

This block is one execution slice of a 32-bit processor pipeline. It takes one instruction word and the value already read from the source register. It checks that the word is the unsigned-saturate encoding and pulls out its fields. The source value is then shifted by an immediate amount, either left or arithmetically right. The shifted value is read as a signed 32-bit number and clamped into the range 0 to 2^N−1, where N is a 5-bit field in the word. The clamped value is sent out with its destination index and a write enable.

The condition code is evaluated elsewhere, and its verdict arrives on `cond_pass_i`. A sticky saturation flag records any clamp that altered a value. Software clears it with a one-cycle synchronous clear. The signed-saturate sibling encoding and any malformed word are not executed. Each one raises a one-cycle unsupported indication instead.

Top module: `shsat_unit`

## Requirements
- R1: Fields sit at fixed positions in `insn_i`. Destination index is bits 15:12, saturation position N is bits 20:16, shift amount is bits 11:7, and shift kind is bit 6. Bits 31:28 are not decoded. For example, 0xE6E088D5 carries destination 8, N=0, an arithmetic right shift of 17.
- R2: Shift kind 0 shifts the source left logically. Shift kind 1 shifts it right arithmetically, replicating bit 31. A shift amount of 0 leaves the value unchanged for either kind.
- R3: With s the shifted value read as signed, the result is 0 when s < 0, 2^N−1 when s > 2^N−1, and s otherwise.
- R4: With N = 0, every input yields a result of 0.
- R5: A word executes only if bits 27:21 equal 0110111 and bits 5:4 equal 01. Any other word pulses `unsup_o` one cycle after its strobe and gives no write.
- R6: The signed form is the same pattern with bit 22 at 0. It raises `unsup_o` and does not write.
- R7: A valid, supported word with `cond_pass_i` low gives no write and leaves `q_flag_o` unchanged.
- R8: `q_flag_o` is set one cycle after a written operation whose clamp changed the value. It stays set afterwards, and a clamp that leaves the value unchanged does not set it.
- R9: `q_clr_i` clears `q_flag_o` at the next edge. If a saturating write happens in the same cycle, the flag ends up set.
- R10: `wr_en_o`, `rd_o` and `result_o` are registered. `wr_en_o` is a one-cycle pulse in the cycle after the strobe. No strobe means no write, and back-to-back strobes each give their own result.
- R11: After reset, `wr_en_o`, `unsup_o`, `q_flag_o`, `rd_o` and `result_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Strobe: `insn_i` and `src_i` hold an operation this cycle |
| insn_i | input | 32 | Instruction word |
| src_i | input | 32 | Source register value |
| cond_pass_i | input | 1 | Condition-code verdict for this operation |
| q_clr_i | input | 1 | Synchronous clear of the saturation flag |
| rd_o | output | 4 | Destination register index of the last write |
| result_o | output | 32 | Clamped value of the last write |
| wr_en_o | output | 1 | Write pulse for the register file |
| q_flag_o | output | 1 | Sticky saturation flag |
| unsup_o | output | 1 | Pulse: the strobed word is not an executable encoding |

## Verification
Every result of this block is due exactly one clock edge after its strobe. This covers the write pulse, the destination and data, the unsupported pulse and the updated flag. A driver applies each operation on a falling edge and queues the expected outcome. A monitor flags a strobe seen at the rising edge and pops and compares on the falling edge that follows. Because of this, back-to-back operations line up one for one. The flag's clear and its reset state are checked directly on the falling edge after the edge concerned.

// File: rtl/shsat_pkg.sv
`timescale 1ns/1ps
package shsat_pkg;

    localparam int INSN_W   = 32;
    localparam int REG_W    = 4;
    localparam int FIELD5_W = 5;

    // fixed encoding positions, decoded by this unit
    localparam int RD_LSB   = 12;
    localparam int SATP_LSB = 16;
    localparam int SHAM_LSB = 7;
    localparam int KIND_BIT = 6;
    localparam int FORM_BIT = 22;

    localparam logic [6:0] OPC_HI = 7'b0110111;
    localparam logic [1:0] OPC_LO = 2'b01;

    typedef struct packed {
        logic [REG_W-1:0]    rd;
        logic [FIELD5_W-1:0] satpos;
        logic [FIELD5_W-1:0] shamt;
        logic                asr;
        logic                exec_ok;
    } dec_t;

endpackage

// File: rtl/shsat_decode.sv
`timescale 1ns/1ps
module shsat_decode
    import shsat_pkg::*;
(
    input  logic [INSN_W-1:0] insn_i,
    output dec_t              dec_o
);
    logic unused_cond;
    logic hi_match;
    logic lo_match;

    assign unused_cond = ^insn_i[31:28];

    // bit 22 is part of OPC_HI, so the signed form fails this match
    assign hi_match = (insn_i[27:21] == OPC_HI);
    assign lo_match = (insn_i[5:4] == OPC_LO);

    always_comb begin
        dec_o.rd      = insn_i[RD_LSB +: REG_W];
        dec_o.satpos  = insn_i[SATP_LSB +: FIELD5_W];
        dec_o.shamt   = insn_i[SHAM_LSB +: FIELD5_W];
        dec_o.asr     = insn_i[KIND_BIT];
        dec_o.exec_ok = hi_match && lo_match && insn_i[FORM_BIT];
    end

endmodule

// File: rtl/shsat_clamp.sv
`timescale 1ns/1ps
module shsat_clamp #(
    parameter int DATA_W = 32,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] src_i,
    input  logic [SH_W-1:0]   shamt_i,
    input  logic              asr_i,
    input  logic [SH_W-1:0]   satpos_i,
    output logic [DATA_W-1:0] res_o,
    output logic              sat_o
);
    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] limit;
    logic              neg;
    logic              over;

    // log-depth barrel shifter, one stage per shift-amount bit
    always_comb begin
        shifted = src_i;
        for (int i = 0; i < SH_W; i++) begin
            if (shamt_i[i]) begin
                if (asr_i) shifted = DATA_W'($signed(shifted) >>> (1 << i));
                else       shifted = shifted << (1 << i);
            end
        end
    end

    always_comb begin
        limit = (DATA_W'(1) << satpos_i) - DATA_W'(1);
        neg   = shifted[DATA_W-1];
        over  = !neg && (shifted > limit);
        if (neg)       res_o = '0;
        else if (over) res_o = limit;
        else           res_o = shifted;
        sat_o = neg || over;
    end

endmodule

// File: rtl/shsat_unit.sv
`timescale 1ns/1ps
module shsat_unit
    import shsat_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              valid_i,
    input  logic [INSN_W-1:0] insn_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic              cond_pass_i,
    input  logic              q_clr_i,
    output logic [REG_W-1:0]  rd_o,
    output logic [DATA_W-1:0] result_o,
    output logic              wr_en_o,
    output logic              q_flag_o,
    output logic              unsup_o
);
    localparam int SH_W = $clog2(DATA_W);

    typedef struct packed {
        logic [DATA_W-1:0] result;
        logic [REG_W-1:0]  rd;
        logic              wr_en;
        logic              unsup;
        logic              q;
    } st_t;

    dec_t              dec;
    logic [DATA_W-1:0] clamp_res;
    logic              clamp_sat;
    st_t               st_d;
    st_t               st_q;

    shsat_decode u_decode (
        .insn_i (insn_i),
        .dec_o  (dec)
    );

    shsat_clamp #(.DATA_W(DATA_W)) u_clamp (
        .src_i    (src_i),
        .shamt_i  (SH_W'(dec.shamt)),
        .asr_i    (dec.asr),
        .satpos_i (SH_W'(dec.satpos)),
        .res_o    (clamp_res),
        .sat_o    (clamp_sat)
    );

    always_comb begin
        st_d       = st_q;
        st_d.wr_en = 1'b0;
        st_d.unsup = 1'b0;
        if (q_clr_i) st_d.q = 1'b0;
        if (valid_i) begin
            if (!dec.exec_ok) begin
                st_d.unsup = 1'b1;
            end else if (cond_pass_i) begin
                st_d.wr_en  = 1'b1;
                st_d.rd     = dec.rd;
                st_d.result = clamp_res;
                if (clamp_sat) st_d.q = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rd_o     = st_q.rd;
    assign result_o = st_q.result;
    assign wr_en_o  = st_q.wr_en;
    assign q_flag_o = st_q.q;
    assign unsup_o  = st_q.unsup;

endmodule

// File: rtl/shsat_unit_chk.sv
`timescale 1ns/1ps
module shsat_unit_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              valid_i,
    input logic              cond_pass_i,
    input logic              q_clr_i,
    input logic [4:0]        satpos,
    input logic [1:0]        tail,
    input logic [DATA_W-1:0] result_o,
    input logic              wr_en_o,
    input logic              q_flag_o,
    input logic              unsup_o
);
    AST_WR_AFTER_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_o |-> $past(valid_i && cond_pass_i)); // R10

    AST_NO_WR_COND_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && !cond_pass_i) |=> !wr_en_o); // R7

    AST_BAD_TAIL_UNSUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && tail != 2'b01) |=> (unsup_o && !wr_en_o)); // R5

    AST_UNSUP_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        unsup_o |-> !wr_en_o); // R6

    AST_RESULT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_o |-> ((result_o >> $past(satpos)) == '0)); // R3

    AST_Q_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q_flag_o && !q_clr_i) |=> q_flag_o); // R8

    AST_Q_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q_clr_i && !valid_i) |=> !q_flag_o); // R9

endmodule

bind shsat_unit shsat_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (valid_i),
    .cond_pass_i (cond_pass_i),
    .q_clr_i     (q_clr_i),
    .satpos      (insn_i[20:16]),
    .tail        (insn_i[5:4]),
    .result_o    (result_o),
    .wr_en_o     (wr_en_o),
    .q_flag_o    (q_flag_o),
    .unsup_o     (unsup_o)
);

// File: tb/shsat_unit_tb.sv
`timescale 1ns/1ps
module shsat_unit_tb;
    localparam int CLK_P = 10;

    typedef struct {
        logic        wr;
        logic        unsup;
        logic        q;
        logic [3:0]  rd;
        logic [31:0] res;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid = 1'b0;
    logic [31:0] insn = '0;
    logic [31:0] src = '0;
    logic        cond = 1'b0;
    logic        qclr = 1'b0;
    logic [3:0]  rd_o;
    logic [31:0] result_o;
    logic        wr_en_o, q_flag_o, unsup_o;

    int   n_run = 0;
    int   n_fail = 0;
    logic q_m = 1'b0;
    logic due = 1'b0;
    bit   finished = 0;
    exp_t sb[$];

    shsat_unit u_dut (
        .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .insn_i(insn),
        .src_i(src), .cond_pass_i(cond), .q_clr_i(qclr),
        .rd_o(rd_o), .result_o(result_o), .wr_en_o(wr_en_o),
        .q_flag_o(q_flag_o), .unsup_o(unsup_o)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc(int rd, int n, int sh, bit asr);
        return 32'hE6E00010 | (32'(n) << 16) | (32'(rd) << 12) | (32'(sh) << 7) | (32'(asr) << 6);
    endfunction

    // independent reference from the requirements
    task automatic issue(logic [31:0] w, logic [31:0] s, logic c, logic clr, string tag);
        exp_t e;
        logic good;
        int   sh, n;
        logic [31:0] sv;
        longint sval, lim;
        @(negedge clk);
        insn = w; src = s; cond = c; qclr = clr; valid = 1'b1;
        good = (w[27:21] == 7'b0110111) && (w[5:4] == 2'b01);
        sh = int'(w[11:7]);
        n  = int'(w[20:16]);
        sv = w[6] ? 32'($signed(s) >>> sh) : (s << sh);
        sval = longint'($signed(sv));
        lim  = (longint'(1) << n) - 1;
        if (clr) q_m = 1'b0;
        e.tag = tag; e.wr = 0; e.unsup = !good; e.rd = w[15:12]; e.res = '0;
        if (good && c) begin
            e.wr = 1;
            if (sval < 0)        begin e.res = '0;         q_m = 1'b1; end
            else if (sval > lim) begin e.res = 32'(lim);   q_m = 1'b1; end
            else                       e.res = sv;
        end
        e.q = q_m;
        sb.push_back(e);
    endtask

    task automatic idle(int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            valid = 1'b0; qclr = 1'b0; cond = 1'b0;
        end
    endtask

    // monitor: a strobe seen at a rising edge is compared at the next falling edge
    always @(posedge clk) due <= valid && rst_n;

    always @(negedge clk) begin
        if (due) begin
            exp_t e;
            if (sb.size() == 0) begin
                chk("R10", "unexpected result", 32'd1, 32'd0);
            end else begin
                e = sb.pop_front();
                chk(e.tag, "wr_en", 32'(wr_en_o), 32'(e.wr));
                chk(e.tag, "unsup", 32'(unsup_o), 32'(e.unsup));
                chk(e.tag, "q_flag", 32'(q_flag_o), 32'(e.q));
                if (e.wr) begin
                    chk(e.tag, "rd", 32'(rd_o), 32'(e.rd));
                    chk(e.tag, "result", result_o, e.res);
                end
            end
        end
    end

    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "reset wr_en", 32'(wr_en_o), 0);
        chk("R11", "reset unsup", 32'(unsup_o), 0);
        chk("R11", "reset q", 32'(q_flag_o), 0);
        chk("R11", "reset result", result_o, 0);
        chk("R11", "reset rd", 32'(rd_o), 0);

        // R3 / R8: in-range value leaves the flag clear
        issue(enc(2, 12, 9, 1), 32'h0000FFFF, 1, 0, "R3_asr9");
        idle(1);
        // R3 / R8: over range and negative after left shift
        issue(enc(1, 8, 0, 0), 32'h0000FFFF, 1, 0, "R8_over");
        issue(enc(3, 1, 16, 0), 32'h0000FFFF, 1, 0, "R3_neg");
        // R1: fixed encodings, back to back (R10)
        issue(32'hE6E10011, 32'd1, 1, 0, "R1_e0");
        issue(32'hE6E10011, 32'd5, 1, 0, "R1_e0sat");
        issue(32'hE6FF3F94, 32'd1, 1, 0, "R1_e3");
        issue(32'hE6E088D5, 32'h00040000, 1, 0, "R1_e8");
        idle(1);
        // R2: ASR replicates sign, zero amount is no shift
        issue(enc(4, 20, 16, 1), 32'hFFFF0000, 1, 0, "R2_asrneg");
        issue(enc(5, 20, 0, 1), 32'h00012345, 1, 0, "R2_asr0");
        issue(enc(6, 31, 0, 0), 32'h7FFFFFFF, 1, 0, "R2_lsl0");
        issue(enc(7, 16, 4, 0), 32'h00000ABC, 1, 0, "R2_lsl4");
        idle(1);
        // R9: clear alone
        @(negedge clk); qclr = 1'b1; q_m = 1'b0;
        @(negedge clk); qclr = 1'b0;
        chk("R9", "q after clear", 32'(q_flag_o), 0);
        // R4: N = 0
        issue(enc(9, 0, 0, 0), 32'd0, 1, 0, "R4_zero");
        issue(enc(9, 0, 0, 0), 32'h12345678, 1, 0, "R4_any");
        idle(1);
        // R7: condition fails on saturating input, flag untouched
        @(negedge clk); qclr = 1'b1; q_m = 1'b0;
        @(negedge clk); qclr = 1'b0;
        issue(enc(10, 4, 0, 0), 32'hFFFFFFFF, 0, 0, "R7_nocond");
        idle(1);
        // R5: pattern mismatch, R6: signed form
        issue(enc(11, 8, 0, 0) ^ 32'h08000000, 32'd1, 1, 0, "R5_hi");
        issue(enc(11, 8, 0, 0) & ~32'h00000030, 32'd1, 1, 0, "R5_lo");
        issue(enc(11, 8, 0, 0) & ~32'h00400000, 32'd1, 1, 0, "R6_signed");
        idle(1);
        // R9: clear and saturating write together
        issue(enc(12, 3, 0, 0), 32'd100, 1, 1, "R9_both");
        idle(1);
        // R10: no strobe, no write
        @(negedge clk);
        chk("R10", "idle wr_en", 32'(wr_en_o), 0);
        idle(2);
        chk("R10", "scoreboard drained", 32'(sb.size()), 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule